// File: doc/BRIEF.md
# Dual Multiplier Adder with Result Feedback

This block takes two pairs of operands, forms the two products and combines them into one wide result. It suits butterfly, complex-filter and recursive-filter datapaths. Whether the second product is added to or subtracted from the first is fixed when the block is built. Two runtime flags choose signed or unsigned handling of the a-side and b-side operands. The full-precision combination passes through an output stage that can round and saturate to a 36-bit signed word, and raises a flag in any cycle where it clamps.

A build-time option turns on a feedback path. When it is on, the upper 18 bits of the registered 36-bit result replace the a-operand of the first multiplier. The low half is discarded. A runtime kill input forces that fed-back operand to zero.

Every register sits behind one clock enable and one asynchronous clear. The pipeline has three stages: operand capture, product capture and output capture. A sample therefore reaches the outputs three enabled clock edges after it is presented.

Top module: `dual_mul_add_fb`

## Requirements
- R1: With the add variant, acc_o equals opa0*opb0 + opa1*opb1 reduced to 36 bits, and res_o equals acc_o[35:18]. Operands held at the inputs appear at the outputs after the third rising clock edge with ce high.
- R2: a_signed=1 treats opa0 and opa1 as two's complement and a_signed=0 treats them as unsigned. b_signed does the same for opb0 and opb1.
- R3: With the subtract variant (parameter SUBTRACT=1), acc_o equals opa0*opb0 - opa1*opb1.
- R4: With LOOPBACK=1 and fb_kill=0, the first multiplier's a-operand is the value of res_o at the capturing edge, and opa0 has no effect.
- R5: With LOOPBACK=1 and fb_kill=1, the first multiplier's a-operand is zero.
- R6: rnd_en=1 adds 2^17 (half of the res_o LSB) to the full-precision result before it is reduced.
- R7: sat_en=1 clamps a result above 2^35-1 to 36'h7FFFFFFFF and a result below -2^35 to 36'h800000000, with ovf=1 for that result. With sat_en=0 the low 36 bits are kept and ovf=0. ovf=1 only ever accompanies one of the two rail values.
- R8: While ce=0, no register changes, so acc_o, res_o and ovf hold.
- R9: arst=1 clears every register at once, without waiting for a clock edge: acc_o=0, res_o=0, ovf=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| arst | input | 1 | Asynchronous clear, active high |
| ce | input | 1 | Clock enable for all registers |
| a_signed | input | 1 | 1: a-side operands are two's complement |
| b_signed | input | 1 | 1: b-side operands are two's complement |
| rnd_en | input | 1 | Add half LSB of res_o before reduction |
| sat_en | input | 1 | Clamp to the 36-bit signed range |
| fb_kill | input | 1 | Force the fed-back operand to zero |
| opa0 | input | 18 | First multiplier a-operand (unused when feedback is built) |
| opb0 | input | 18 | First multiplier b-operand |
| opa1 | input | 18 | Second multiplier a-operand |
| opb1 | input | 18 | Second multiplier b-operand |
| acc_o | output | 36 | Rounded and saturated or wrapped result |
| res_o | output | 18 | Upper half of acc_o, also the feedback value |
| ovf | output | 1 | Saturation occurred for this result |

## Verification
A corrupted product or control register surfaces on acc_o exactly two enabled edges later, and a corrupted operand register after three. The bench therefore samples at that fixed depth. When the feedback register is wrong, the error comes back into the next sample, so an error in the loop keeps recirculating rather than fading. A wrong rounding or saturation control shows as a result off by 2^17 or as a missing rail value with ovf, in the same cycle as the data it travels with.

// File: rtl/dmafb_pkg.sv
`timescale 1ns/1ps
package dmafb_pkg;
    // Output-stage controls travel with their sample through the pipe.
    typedef struct packed {
        logic rnd;
        logic sat;
    } ostage_ctl_t;

    localparam int unsigned OPW_DEFAULT = 18;
endpackage

// File: rtl/dmafb_in_stage.sv
`timescale 1ns/1ps
module dmafb_in_stage
    import dmafb_pkg::*;
#(
    parameter int unsigned W        = OPW_DEFAULT,
    parameter bit          LOOPBACK = 1'b0
) (
    input  logic          clk,
    input  logic          arst,
    input  logic          ce,
    input  logic          a_signed,
    input  logic          b_signed,
    input  logic          rnd_en,
    input  logic          sat_en,
    input  logic          fb_kill,
    input  logic [W-1:0]  opa0,
    input  logic [W-1:0]  opb0,
    input  logic [W-1:0]  opa1,
    input  logic [W-1:0]  opb1,
    input  logic [W-1:0]  fb_val,
    output logic [W-1:0]  xa0_q,
    output logic [W-1:0]  xb0_q,
    output logic [W-1:0]  xa1_q,
    output logic [W-1:0]  xb1_q,
    output logic          as_q,
    output logic          bs_q,
    output ostage_ctl_t   ctl_q
);
    logic [W-1:0] a0_src;

    generate
        if (LOOPBACK) begin : g_fb
            // Upper half of the registered result, or zero when killed.
            assign a0_src = fb_kill ? '0 : fb_val;
        end else begin : g_direct
            assign a0_src = opa0;
        end
    endgenerate

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            xa0_q <= '0;
            xb0_q <= '0;
            xa1_q <= '0;
            xb1_q <= '0;
            as_q  <= 1'b0;
            bs_q  <= 1'b0;
            ctl_q <= '0;
        end else if (ce) begin
            xa0_q <= a0_src;
            xb0_q <= opb0;
            xa1_q <= opa1;
            xb1_q <= opb1;
            as_q  <= a_signed;
            bs_q  <= b_signed;
            ctl_q <= '{rnd: rnd_en, sat: sat_en};
        end
    end
endmodule

// File: rtl/dmafb_mul.sv
`timescale 1ns/1ps
module dmafb_mul #(
    parameter int unsigned W  = 18,
    localparam int unsigned PW = 2*W + 2
) (
    input  logic [W-1:0]         x,
    input  logic [W-1:0]         y,
    input  logic                 x_signed,
    input  logic                 y_signed,
    output logic signed [PW-1:0] p
);
    // One extra bit turns either interpretation into a signed operand.
    logic signed [W:0] xe;
    logic signed [W:0] ye;

    assign xe = {x_signed & x[W-1], x};
    assign ye = {y_signed & y[W-1], y};
    assign p  = xe * ye;
endmodule

// File: rtl/dmafb_out_stage.sv
`timescale 1ns/1ps
module dmafb_out_stage
    import dmafb_pkg::*;
#(
    parameter int unsigned W        = OPW_DEFAULT,
    parameter bit          SUBTRACT = 1'b0,
    localparam int unsigned PW = 2*W + 2,
    localparam int unsigned SW = PW + 1,
    localparam int unsigned OW = 2*W
) (
    input  logic                 clk,
    input  logic                 arst,
    input  logic                 ce,
    input  logic signed [PW-1:0] p0,
    input  logic signed [PW-1:0] p1,
    input  ostage_ctl_t          ctl,
    output logic [OW-1:0]        acc_q,
    output logic                 ovf_q
);
    localparam logic signed [SW-1:0] HALF = {{(SW-W){1'b0}}, 1'b1, {(W-1){1'b0}}};
    localparam logic signed [SW-1:0] MAXP = {{(SW-OW+1){1'b0}}, {(OW-1){1'b1}}};
    localparam logic signed [SW-1:0] MINN = {{(SW-OW+1){1'b1}}, {(OW-1){1'b0}}};

    logic signed [SW-1:0] s0, s1, comb, rsum;
    logic                 hi_out, lo_out;
    logic [OW-1:0]        acc_d;
    logic                 ovf_d;

    assign s0 = SW'(p0);
    assign s1 = SW'(p1);

    generate
        if (SUBTRACT) begin : g_sub
            assign comb = s0 - s1;
        end else begin : g_add
            assign comb = s0 + s1;
        end
    endgenerate

    assign rsum   = ctl.rnd ? (comb + HALF) : comb;
    assign hi_out = rsum > MAXP;
    assign lo_out = rsum < MINN;

    always_comb begin
        acc_d = rsum[OW-1:0];
        ovf_d = 1'b0;
        if (ctl.sat && hi_out) begin
            acc_d = {1'b0, {(OW-1){1'b1}}};
            ovf_d = 1'b1;
        end else if (ctl.sat && lo_out) begin
            acc_d = {1'b1, {(OW-1){1'b0}}};
            ovf_d = 1'b1;
        end
    end

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            acc_q <= '0;
            ovf_q <= 1'b0;
        end else if (ce) begin
            acc_q <= acc_d;
            ovf_q <= ovf_d;
        end
    end
endmodule

// File: rtl/dual_mul_add_fb.sv
`timescale 1ns/1ps
module dual_mul_add_fb
    import dmafb_pkg::*;
#(
    parameter int unsigned W        = OPW_DEFAULT,
    parameter bit          SUBTRACT = 1'b0,
    parameter bit          LOOPBACK = 1'b0,
    localparam int unsigned PW = 2*W + 2,
    localparam int unsigned OW = 2*W,
    localparam int unsigned NL = 2
) (
    input  logic          clk,
    input  logic          arst,
    input  logic          ce,
    input  logic          a_signed,
    input  logic          b_signed,
    input  logic          rnd_en,
    input  logic          sat_en,
    input  logic          fb_kill,
    input  logic [W-1:0]  opa0,
    input  logic [W-1:0]  opb0,
    input  logic [W-1:0]  opa1,
    input  logic [W-1:0]  opb1,
    output logic [OW-1:0] acc_o,
    output logic [W-1:0]  res_o,
    output logic          ovf
);
    logic [W-1:0]         xa_s1 [NL];
    logic [W-1:0]         xb_s1 [NL];
    logic [W-1:0]         xa0_s1;
    logic                 as_s1, bs_s1;
    ostage_ctl_t          ctl_s1, ctl_s2;
    logic signed [PW-1:0] prod_c [NL];
    logic signed [PW-1:0] prod_s2 [NL];

    dmafb_in_stage #(.W(W), .LOOPBACK(LOOPBACK)) u_in (
        .clk(clk), .arst(arst), .ce(ce),
        .a_signed(a_signed), .b_signed(b_signed),
        .rnd_en(rnd_en), .sat_en(sat_en), .fb_kill(fb_kill),
        .opa0(opa0), .opb0(opb0), .opa1(opa1), .opb1(opb1),
        .fb_val(res_o),
        .xa0_q(xa_s1[0]), .xb0_q(xb_s1[0]),
        .xa1_q(xa_s1[1]), .xb1_q(xb_s1[1]),
        .as_q(as_s1), .bs_q(bs_s1), .ctl_q(ctl_s1)
    );

    assign xa0_s1 = xa_s1[0];

    generate
        for (genvar g = 0; g < NL; g++) begin : g_lane
            dmafb_mul #(.W(W)) u_mul (
                .x(xa_s1[g]), .y(xb_s1[g]),
                .x_signed(as_s1), .y_signed(bs_s1),
                .p(prod_c[g])
            );

            always_ff @(posedge clk or posedge arst) begin
                if (arst) begin
                    prod_s2[g] <= '0;
                end else if (ce) begin
                    prod_s2[g] <= prod_c[g];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            ctl_s2 <= '0;
        end else if (ce) begin
            ctl_s2 <= ctl_s1;
        end
    end

    dmafb_out_stage #(.W(W), .SUBTRACT(SUBTRACT)) u_out (
        .clk(clk), .arst(arst), .ce(ce),
        .p0(prod_s2[0]), .p1(prod_s2[1]), .ctl(ctl_s2),
        .acc_q(acc_o), .ovf_q(ovf)
    );

    assign res_o = acc_o[OW-1:W];
endmodule

// File: rtl/dual_mul_add_fb_chk.sv
`timescale 1ns/1ps
module dual_mul_add_fb_chk #(
    parameter int unsigned W        = 18,
    parameter bit          LOOPBACK = 1'b0,
    localparam int unsigned OW = 2*W
) (
    input logic          clk,
    input logic          arst,
    input logic          ce,
    input logic          fb_kill,
    input logic [OW-1:0] acc_o,
    input logic [W-1:0]  res_o,
    input logic          ovf,
    input logic          sat_s2,
    input logic [W-1:0]  a0_s1
);
    localparam logic [OW-1:0] RAIL_HI = {1'b0, {(OW-1){1'b1}}};
    localparam logic [OW-1:0] RAIL_LO = {1'b1, {(OW-1){1'b0}}};

    AST_OVF_AT_RAIL: assert property (@(posedge clk) disable iff (arst)
        ovf |-> (acc_o == RAIL_HI || acc_o == RAIL_LO)); // R7
    AST_NO_SAT_NO_OVF: assert property (@(posedge clk) disable iff (arst)
        (ce && !sat_s2) |=> !ovf); // R7
    AST_HOLD_ON_IDLE: assert property (@(posedge clk) disable iff (arst)
        !ce |=> ($stable(acc_o) && $stable(ovf))); // R8
    AST_FB_ZEROED: assert property (@(posedge clk) disable iff (arst)
        (LOOPBACK && ce && fb_kill) |=> (a0_s1 == '0)); // R5
    AST_FB_TAKEN: assert property (@(posedge clk) disable iff (arst)
        (LOOPBACK && ce && !fb_kill) |=> (a0_s1 == $past(res_o))); // R4

    always @(posedge clk) begin
        if (arst) begin
            AST_CLEARED: assert (acc_o == '0 && !ovf); // R9
        end
    end
endmodule

bind dual_mul_add_fb dual_mul_add_fb_chk #(.W(W), .LOOPBACK(LOOPBACK)) u_chk (
    .clk(clk), .arst(arst), .ce(ce), .fb_kill(fb_kill),
    .acc_o(acc_o), .res_o(res_o), .ovf(ovf),
    .sat_s2(ctl_s2.sat), .a0_s1(xa0_s1)
);

// File: tb/tb_dual_mul_add_fb.sv
`timescale 1ns/1ps
module tb_dual_mul_add_fb;
    logic clk = 1'b0;
    logic arst = 1'b1;
    logic ce = 1'b1;
    logic a_signed = 1'b0, b_signed = 1'b0, rnd_en = 1'b0, sat_en = 1'b0, fb_kill = 1'b0;
    logic [17:0] opa0 = '0, opb0 = '0, opa1 = '0, opb1 = '0;
    logic [35:0] acc_a, acc_s, acc_l;
    logic [17:0] res_a, res_s, res_l;
    logic        ovf_a, ovf_s, ovf_l;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    dual_mul_add_fb #(.SUBTRACT(1'b0), .LOOPBACK(1'b0)) dut (
        .clk(clk), .arst(arst), .ce(ce), .a_signed(a_signed), .b_signed(b_signed),
        .rnd_en(rnd_en), .sat_en(sat_en), .fb_kill(fb_kill),
        .opa0(opa0), .opb0(opb0), .opa1(opa1), .opb1(opb1),
        .acc_o(acc_a), .res_o(res_a), .ovf(ovf_a));

    dual_mul_add_fb #(.SUBTRACT(1'b1), .LOOPBACK(1'b0)) dut_sub (
        .clk(clk), .arst(arst), .ce(ce), .a_signed(a_signed), .b_signed(b_signed),
        .rnd_en(rnd_en), .sat_en(sat_en), .fb_kill(fb_kill),
        .opa0(opa0), .opb0(opb0), .opa1(opa1), .opb1(opb1),
        .acc_o(acc_s), .res_o(res_s), .ovf(ovf_s));

    dual_mul_add_fb #(.SUBTRACT(1'b0), .LOOPBACK(1'b1)) dut_lb (
        .clk(clk), .arst(arst), .ce(ce), .a_signed(a_signed), .b_signed(b_signed),
        .rnd_en(rnd_en), .sat_en(sat_en), .fb_kill(fb_kill),
        .opa0(opa0), .opb0(opb0), .opa1(opa1), .opb1(opb1),
        .acc_o(acc_l), .res_o(res_l), .ovf(ovf_l));

    // {a_signed, b_signed, rnd_en, sat_en, opa0, opb0, opa1, opb1}
    localparam int NV = 10;
    localparam logic [75:0] VEC [NV] = '{
        {4'b1100, 18'd3,      18'd5,      18'd7,      18'd11},
        {4'b1100, 18'h3FFFF,  18'd16,     18'd2,      18'h3FFFE},
        {4'b0000, 18'h3FFFF,  18'h3FFFF,  18'd1,      18'd1},
        {4'b1000, 18'h3FFFF,  18'h3FFFF,  18'd0,      18'd0},
        {4'b0100, 18'h3FFFF,  18'h3FFFF,  18'd0,      18'd0},
        {4'b0010, 18'd1,      18'h20000,  18'd0,      18'd0},
        {4'b1101, 18'h20000,  18'h20000,  18'h20000,  18'h20000},
        {4'b1100, 18'h20000,  18'h20000,  18'h20000,  18'h20000},
        {4'b1001, 18'h20000,  18'h3FFFF,  18'h20000,  18'h3FFFF},
        {4'b1111, 18'h1FFFF,  18'h1FFFF,  18'h1FFFF,  18'h1FFFF}
    };

    function automatic longint ext(input logic [17:0] v, input logic sg);
        return sg ? longint'($signed(v)) : longint'({46'd0, v});
    endfunction

    // Returns {ovf, acc} from the requirement text alone.
    function automatic logic [36:0] model(input logic [75:0] v, input bit sub);
        longint p0, p1, s;
        longint hi, lo;
        p0 = ext(v[71:54], v[75]) * ext(v[53:36], v[74]);
        p1 = ext(v[35:18], v[75]) * ext(v[17:0], v[74]);
        s  = sub ? p0 - p1 : p0 + p1;
        if (v[73]) s = s + 131072;
        hi = (longint'(1) <<< 35) - 1;
        lo = -(longint'(1) <<< 35);
        if (v[72] && s > hi) return {1'b1, 36'h7FFFFFFFF};
        if (v[72] && s < lo) return {1'b1, 36'h800000000};
        return {1'b0, s[35:0]};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [75:0] v);
        {a_signed, b_signed, rnd_en, sat_en} = v[75:72];
        opa0 = v[71:54]; opb0 = v[53:36]; opa1 = v[35:18]; opb1 = v[17:0];
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1;
        check("R9 reset acc", 64'(acc_a), 64'd0);
        check("R9 reset ovf", 64'(ovf_a), 64'd0);
        @(negedge clk);
        arst = 1'b0;

        // Table walk: R1/R2 on the add build, R3 on the subtract build.
        for (int i = 0; i < NV; i++) begin
            logic [36:0] ea, es;
            apply(VEC[i]);
            settle();
            ea = model(VEC[i], 1'b0);
            es = model(VEC[i], 1'b1);
            check("R1/R2 acc", 64'(acc_a), 64'(ea[35:0]));
            check("R1 res upper half", 64'(res_a), 64'(ea[35:18]));
            check("R7 ovf", 64'(ovf_a), 64'(ea[36]));
            check("R3 sub acc", 64'(acc_s), 64'(es[35:0]));
        end

        // R1 latency: after only two edges the old result must still show.
        apply({4'b1100, 18'd3, 18'd5, 18'd7, 18'd11});
        settle();
        apply({4'b1100, 18'd2, 18'd2, 18'd0, 18'd0});
        repeat (2) @(posedge clk); @(negedge clk);
        check("R1 latency two edges", 64'(acc_a), 64'd92);
        @(negedge clk);
        check("R1 latency three edges", 64'(acc_a), 64'd4);

        // R2 directed: 3*5 - 7*11 on subtract build, signed.
        apply({4'b1100, 18'd3, 18'd5, 18'd7, 18'd11});
        settle();
        check("R3 sub hand value", 64'(acc_s), 64'(36'hFFFFFFFC2));
        // R2 unsigned all-ones times one.
        apply({4'b0000, 18'h3FFFF, 18'd1, 18'd0, 18'd0});
        settle();
        check("R2 unsigned operand", 64'(acc_a), 64'd262143);

        // R6 rounding on and off.
        apply({4'b0010, 18'd1, 18'h20000, 18'd0, 18'd0});
        settle();
        check("R6 round on", 64'(acc_a), 64'd262144);
        check("R6 round on res", 64'(res_a), 64'd1);
        apply({4'b0000, 18'd1, 18'h20000, 18'd0, 18'd0});
        settle();
        check("R6 round off", 64'(acc_a), 64'd131072);

        // R7 rails and wrap.
        apply({4'b1101, 18'h20000, 18'h20000, 18'h20000, 18'h20000});
        settle();
        check("R7 clamp high", 64'(acc_a), 64'(36'h7FFFFFFFF));
        check("R7 ovf high", 64'(ovf_a), 64'd1);
        apply({4'b1100, 18'h20000, 18'h20000, 18'h20000, 18'h20000});
        settle();
        check("R7 wrap without sat", 64'(acc_a), 64'(36'h800000000));
        check("R7 no ovf without sat", 64'(ovf_a), 64'd0);
        apply({4'b1001, 18'h20000, 18'h3FFFF, 18'h20000, 18'h3FFFF});
        settle();
        check("R7 clamp low", 64'(acc_a), 64'(36'h800000000));
        check("R7 ovf low", 64'(ovf_a), 64'd1);

        // R8: ce low freezes everything despite new operands.
        apply({4'b1100, 18'd3, 18'd5, 18'd7, 18'd11});
        settle();
        ce = 1'b0;
        apply({4'b1100, 18'd100, 18'd100, 18'd9, 18'd9});
        repeat (5) @(posedge clk); @(negedge clk);
        check("R8 hold acc", 64'(acc_a), 64'd92);
        ce = 1'b1;
        settle();
        check("R8 resume", 64'(acc_a), 64'd10081);

        // R5: feedback killed, opa0 all ones must not matter.
        fb_kill = 1'b1;
        apply({4'b1100, 18'h3FFFF, 18'd5, 18'd512, 18'd1024});
        settle();
        check("R5 killed operand", 64'(acc_l), 64'd524288);
        check("R5 killed res", 64'(res_l), 64'd2);
        // R4: feedback live; res_o = 2 enters as a-operand of lane 0.
        fb_kill = 1'b0;
        settle();
        check("R4 feedback used", 64'(acc_l), 64'd524298);
        check("R4 res steady", 64'(res_l), 64'd2);

        // R9: asynchronous clear between edges.
        #1;
        arst = 1'b1;
        #0.5;
        check("R9 async acc", 64'(acc_a), 64'd0);
        check("R9 async lb", 64'(acc_l), 64'd0);
        check("R9 async ovf", 64'(ovf_a), 64'd0);
        @(negedge clk);
        arst = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule